// File: doc/BRIEF.md
# Cartridge CHR bank and nametable-select controller

This block sits on the CPU side of a game-cartridge memory mapper. It captures CPU writes to a small register window at $7EF0-$7EFF. From those registers it turns the top three bits of the video address into the upper CHR ROM address bits and a nametable-select line that drives the console's internal video RAM A10. A strap input chooses between two board wirings. In the standard wiring, a dedicated register sets the mirroring and all eight bank bits reach the ROM. In the alternate wiring, bit 7 of whichever bank register serves the current video access drives the nametable select. That bank bit is then withheld from the ROM, which halves the reachable CHR space.

The block also holds a 128-byte work RAM in the $7F00-$7FFF page. This RAM only answers while a key byte has been written to its enable register. Register writes are committed on the falling edge of the CPU phase clock, which is oversampled by the block clock.

Top module: `chr_nt_mapper`

## Requirements
- R1: After reset all bank registers, the mirroring bit and the RAM enable are zero. So chr_bank_o is {7'b0, ppu_a10} in the low 4 KB and 0 in the high 4 KB, ciram_a10_o follows ppu_a11 in standard mode, and the RAM output enable stays low.
- R2: Registers $7EF0 and $7EF1 map video $0000-$07FF and $0800-$0FFF as 2 KB banks. chr_bank_o is {reg[7:1], ppu_a10}, so bit 0 of the register is ignored.
- R3: Registers $7EF2, $7EF3, $7EF4 and $7EF5 map the 1 KB regions at $1000, $1400, $1800 and $1C00. chr_bank_o is the whole register.
- R4: In standard mode (alt_mode_i=0) all eight register bits reach chr_bank_o, and bit 7 of a bank register has no effect on ciram_a10_o.
- R5: In standard mode a write to $7EF6 sets mirroring from data bit 0 only. With 1 (vertical), ciram_a10_o = ppu_a10. With 0 (horizontal), ciram_a10_o = ppu_a11.
- R6: In alternate mode (alt_mode_i=1) chr_bank_o[7] is 0 and ciram_a10_o is bit 7 of the bank register selected by ppu_a12..a10.
- R7: In alternate mode writes to $7EF6/$7EF7 leave the mirroring bit unchanged.
- R8: From $7EF6 upward, each even address and the following odd address act as the same register ($7EF7 = $7EF6, $7EF9 = $7EF8).
- R9: A register or RAM write takes effect only on a high-to-low transition of m2_i with cpu_rw_i low. The new value appears on the outputs one clock after the clock edge that first samples m2_i low. Cycles with cpu_rw_i high change nothing.
- R10: The RAM is enabled only while the last byte written to $7EF8/$7EF9 is $A3. Any other value disables it, and RAM writes while it is disabled are dropped.
- R11: The 128 RAM bytes are indexed by cpu_addr_i[6:0] across $7F00-$7FFF, so $7F80-$7FFF mirror $7F00-$7F7F.
- R12: cpu_data_oe_o is high only for a read (cpu_rw_i=1) with m2_i high, to $7F00-$7FFF, while the RAM is enabled. Otherwise cpu_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples m2_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m2_i | input | 1 | CPU phase clock; writes commit on its fall |
| cpu_rw_i | input | 1 | CPU read (1) / write (0) |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_data_o | output | 8 | RAM read data |
| cpu_data_oe_o | output | 1 | Drive enable for cpu_data_o |
| alt_mode_i | input | 1 | Board wiring strap: 0 standard, 1 alternate |
| ppu_hi_i | input | 3 | Video address bits {A12, A11, A10} |
| chr_bank_o | output | 8 | CHR ROM address bits A17..A10 |
| ciram_a10_o | output | 1 | Nametable select to video RAM A10 |

## Verification
The bench sets bank values with bit 7 and bit 0 deliberately mixed, then sweeps all eight video regions in both wirings. A design that mis-orders the 1 KB registers, honours bit 0 in a 2 KB region, or leaks bank bit 7 in the wrong mode shows a wrong bank or select. It writes mirroring through the odd alias and with junk in the upper data bits, and repeats the write in alternate mode before switching back. Decoders that ignore the pairing, look past bit 0 or let the alternate-mode write through are caught. It holds a write with m2 high for several cycles before releasing it, and it issues a read-direction pulse to a register, to catch commits on the wrong edge or on reads. The RAM is probed before and after the key, through its mirror, during write cycles, and after a wrong key with a dropped write. A design that keeps decoding with the wrong key, or returns a dropped write's byte, shows up there.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int BANK_W     = 8;
  localparam int CHR_REGS   = 6;
  localparam int SEL_W      = $clog2(CHR_REGS);
  localparam int RAM_AW     = 7;
  localparam int RAM_DEPTH  = 1 << RAM_AW;
  localparam logic [7:0]  RAM_KEY  = 8'hA3;
  localparam logic [11:0] REG_PAGE = 12'h7EF;
  localparam logic [7:0]  RAM_PAGE = 8'h7F;

  typedef enum logic [1:0] {
    SLOT_CHR,
    SLOT_MIRR,
    SLOT_KEY,
    SLOT_NONE
  } slot_e;

  function automatic slot_e slot_of(input logic [3:0] lo);
    if (lo < 4'(CHR_REGS))     return SLOT_CHR;
    else if (lo[3:1] == 3'd3)  return SLOT_MIRR;
    else if (lo[3:1] == 3'd4)  return SLOT_KEY;
    else                       return SLOT_NONE;
  endfunction
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_stb_i,
  input  logic [15:0]                      addr_i,
  input  logic [7:0]                       data_i,
  input  logic                             alt_mode_i,
  output logic [CHR_REGS-1:0][BANK_W-1:0]  chr_regs_o,
  output logic                             mirr_o,
  output logic                             key_ok_o
);
  logic  hit;
  slot_e slot;

  assign hit  = wr_stb_i && (addr_i[15:4] == REG_PAGE);
  assign slot = slot_of(addr_i[3:0]);

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        chr_regs_o[g] <= '0;
      else if (hit && slot == SLOT_CHR && addr_i[3:0] == 4'(g))
        chr_regs_o[g] <= data_i[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mirr_o   <= 1'b0;
      key_ok_o <= 1'b0;
    end else if (hit) begin
      // alternate wiring leaves the mirroring output unconnected
      if (slot == SLOT_MIRR && !alt_mode_i) mirr_o <= data_i[0];
      if (slot == SLOT_KEY) key_ok_o <= (data_i == RAM_KEY);
    end
  end
endmodule

// File: rtl/chr_addr_map.sv
module chr_addr_map
  import mapper_pkg::*;
(
  input  logic [CHR_REGS-1:0][BANK_W-1:0] chr_regs_i,
  input  logic                            mirr_i,
  input  logic                            alt_mode_i,
  input  logic [2:0]                      ppu_hi_i,
  output logic [BANK_W-1:0]               chr_bank_o,
  output logic                            ciram_a10_o
);
  logic [SEL_W-1:0]  sel;
  logic [BANK_W-1:0] reg_q;
  logic [BANK_W-1:0] bank;

  always_comb begin
    if (ppu_hi_i[2]) sel = SEL_W'(2 + ppu_hi_i[1:0]);
    else             sel = SEL_W'(ppu_hi_i[1]);
    reg_q = chr_regs_i[sel];
    bank  = reg_q;
    if (!ppu_hi_i[2]) bank[0] = ppu_hi_i[0];  // 2 KB window: A10 passes through
  end

  always_comb begin
    if (alt_mode_i) begin
      chr_bank_o  = {1'b0, bank[BANK_W-2:0]};
      ciram_a10_o = reg_q[BANK_W-1];
    end else begin
      chr_bank_o  = bank;
      ciram_a10_o = mirr_i ? ppu_hi_i[0] : ppu_hi_i[1];
    end
  end
endmodule

// File: rtl/key_ram.sv
module key_ram
  import mapper_pkg::*;
(
  input  logic        clk_i,
  input  logic        wr_stb_i,
  input  logic        m2_i,
  input  logic        rw_i,
  input  logic        key_ok_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  data_o,
  output logic        oe_o
);
  logic [7:0] mem [RAM_DEPTH];
  logic       win;

  assign win = key_ok_i && (addr_i[15:8] == RAM_PAGE);

  always_ff @(posedge clk_i) begin
    if (wr_stb_i && win) mem[addr_i[RAM_AW-1:0]] <= data_i;
  end

  assign oe_o   = win && rw_i && m2_i;
  assign data_o = oe_o ? mem[addr_i[RAM_AW-1:0]] : 8'h00;
endmodule

// File: rtl/chr_nt_mapper.sv
module chr_nt_mapper
  import mapper_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        m2_i,
  input  logic        cpu_rw_i,
  input  logic [15:0] cpu_addr_i,
  input  logic [7:0]  cpu_data_i,
  output logic [7:0]  cpu_data_o,
  output logic        cpu_data_oe_o,
  input  logic        alt_mode_i,
  input  logic [2:0]  ppu_hi_i,
  output logic [7:0]  chr_bank_o,
  output logic        ciram_a10_o
);
  logic m2_q;
  logic wr_stb;
  logic [CHR_REGS-1:0][BANK_W-1:0] chr_regs;
  logic mirr;
  logic key_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  assign wr_stb = m2_q && !m2_i && !cpu_rw_i;

  mapper_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),
    .addr_i     (cpu_addr_i),
    .data_i     (cpu_data_i),
    .alt_mode_i (alt_mode_i),
    .chr_regs_o (chr_regs),
    .mirr_o     (mirr),
    .key_ok_o   (key_ok)
  );

  chr_addr_map u_map (
    .chr_regs_i  (chr_regs),
    .mirr_i      (mirr),
    .alt_mode_i  (alt_mode_i),
    .ppu_hi_i    (ppu_hi_i),
    .chr_bank_o  (chr_bank_o),
    .ciram_a10_o (ciram_a10_o)
  );

  key_ram u_ram (
    .clk_i    (clk_i),
    .wr_stb_i (wr_stb),
    .m2_i     (m2_i),
    .rw_i     (cpu_rw_i),
    .key_ok_i (key_ok),
    .addr_i   (cpu_addr_i),
    .data_i   (cpu_data_i),
    .data_o   (cpu_data_o),
    .oe_o     (cpu_data_oe_o)
  );
endmodule

// File: rtl/chr_nt_mapper_chk.sv
module chr_nt_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        m2_i,
  input logic        cpu_rw_i,
  input logic [15:0] cpu_addr_i,
  input logic [7:0]  cpu_data_i,
  input logic        cpu_data_oe_o,
  input logic        alt_mode_i,
  input logic [2:0]  ppu_hi_i,
  input logic [7:0]  chr_bank_o,
  input logic        ciram_a10_o
);
  logic m2_c, fall_c, key_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m2_c   <= 1'b0;
      fall_c <= 1'b0;
      key_c  <= 1'b0;
    end else begin
      m2_c   <= m2_i;
      fall_c <= m2_c && !m2_i && !cpu_rw_i;
      if (m2_c && !m2_i && !cpu_rw_i && cpu_addr_i[15:1] == 15'h3F7C)
        key_c <= (cpu_data_i == 8'hA3);
    end
  end

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_data_oe_o |-> (cpu_rw_i && m2_i && cpu_addr_i[15:8] == 8'h7F)); // R12

  AST_OE_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_data_oe_o |-> key_c); // R10

  AST_ALT_MSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_mode_i |-> !chr_bank_o[7]); // R6

  AST_2K_LSB_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ppu_hi_i[2] |-> (chr_bank_o[0] == ppu_hi_i[0])); // R2

  AST_STD_NT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alt_mode_i |-> (ciram_a10_o == ppu_hi_i[0] || ciram_a10_o == ppu_hi_i[1])); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_c && $stable(ppu_hi_i) && $stable(alt_mode_i)) |-> $stable(chr_bank_o)); // R9
endmodule

bind chr_nt_mapper chr_nt_mapper_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .m2_i          (m2_i),
  .cpu_rw_i      (cpu_rw_i),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_data_i    (cpu_data_i),
  .cpu_data_oe_o (cpu_data_oe_o),
  .alt_mode_i    (alt_mode_i),
  .ppu_hi_i      (ppu_hi_i),
  .chr_bank_o    (chr_bank_o),
  .ciram_a10_o   (ciram_a10_o)
);

// File: tb/chr_nt_mapper_bench.sv
`timescale 1ns/1ps
module chr_nt_mapper_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m2_i = 1'b0;
  logic        cpu_rw_i = 1'b1;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic [7:0]  cpu_data_o;
  logic        cpu_data_oe_o;
  logic        alt_mode_i = 1'b0;
  logic [2:0]  ppu_hi_i = '0;
  logic [7:0]  chr_bank_o;
  logic        ciram_a10_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  chr_nt_mapper u_chr_nt_mapper (.*);

  // {alt, ppu_hi[2:0], bank[7:0], ciram}
  localparam logic [12:0] VEC [16] = '{
    {1'b0, 3'd0, 8'h34, 1'b0}, {1'b0, 3'd1, 8'h35, 1'b1},
    {1'b0, 3'd2, 8'hC4, 1'b0}, {1'b0, 3'd3, 8'hC5, 1'b1},
    {1'b0, 3'd4, 8'h81, 1'b0}, {1'b0, 3'd5, 8'h12, 1'b1},
    {1'b0, 3'd6, 8'hFE, 1'b0}, {1'b0, 3'd7, 8'h7F, 1'b1},
    {1'b1, 3'd0, 8'h34, 1'b0}, {1'b1, 3'd1, 8'h35, 1'b0},
    {1'b1, 3'd2, 8'h44, 1'b1}, {1'b1, 3'd3, 8'h45, 1'b1},
    {1'b1, 3'd4, 8'h01, 1'b1}, {1'b1, 3'd5, 8'h12, 1'b0},
    {1'b1, 3'd6, 8'h7E, 1'b1}, {1'b1, 3'd7, 8'h7F, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_map(input logic [2:0] hi, input logic [7:0] eb, input logic ec,
                         input string tag);
    @(negedge clk_i);
    ppu_hi_i = hi;
    #1;
    chk(chr_bank_o == eb, {tag, " bank"}, chr_bank_o, eb);
    chk(ciram_a10_o == ec, {tag, " ciram"}, ciram_a10_o, ec);
  endtask

  task automatic cpu_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_rw_i = rw; m2_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    m2_i = 1'b0;
    @(negedge clk_i);
    cpu_rw_i = 1'b1;
  endtask

  task automatic ram_read(input logic [15:0] a, input logic eoe, input logic [7:0] ed,
                          input string tag);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_rw_i = 1'b1; m2_i = 1'b1;
    #1;
    chk(cpu_data_oe_o == eoe, {tag, " oe"}, cpu_data_oe_o, eoe);
    if (eoe) chk(cpu_data_o == ed, {tag, " data"}, cpu_data_o, ed);
    @(negedge clk_i);
    m2_i = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk_map(3'd1, 8'h01, 1'b0, "R1 hi1");
    chk_map(3'd2, 8'h00, 1'b1, "R1 hi2");
    chk_map(3'd5, 8'h00, 1'b0, "R1 hi5");
    ram_read(16'h7F00, 1'b0, 8'h00, "R1 ram off");

    // program banks, R2 R3
    cpu_cycle(16'h7EF0, 8'h35, 1'b0);
    cpu_cycle(16'h7EF1, 8'hC4, 1'b0);
    cpu_cycle(16'h7EF2, 8'h81, 1'b0);
    cpu_cycle(16'h7EF3, 8'h12, 1'b0);
    cpu_cycle(16'h7EF4, 8'hFE, 1'b0);
    cpu_cycle(16'h7EF5, 8'h7F, 1'b0);

    // R5: junk upper bits, D0=0 -> horizontal
    cpu_cycle(16'h7EF6, 8'hFE, 1'b0);
    chk_map(3'd1, 8'h35, 1'b0, "R5 horiz a11=0");
    chk_map(3'd2, 8'hC4, 1'b1, "R5 horiz a11=1");
    // R8: odd alias sets vertical
    cpu_cycle(16'h7EF7, 8'h01, 1'b0);
    chk_map(3'd1, 8'h35, 1'b1, "R8 alias vert");

    // table walk: R2 R3 R4 (standard), R6 (alternate)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      alt_mode_i = VEC[i][12];
      chk_map(VEC[i][11:9], VEC[i][8:1], VEC[i][0],
              VEC[i][12] ? "R6 alt table" : "R4 std table");
    end

    // R7: mirroring write ignored in alternate mode
    @(negedge clk_i); alt_mode_i = 1'b1;
    cpu_cycle(16'h7EF6, 8'h00, 1'b0);
    @(negedge clk_i); alt_mode_i = 1'b0;
    chk_map(3'd1, 8'h35, 1'b1, "R7 alt mirr ignored");

    // R9: read-direction pulse does not write
    cpu_cycle(16'h7EF0, 8'hAA, 1'b1);
    chk_map(3'd0, 8'h34, 1'b0, "R9 rw high ignored");

    // R9: no commit while m2 held high
    @(negedge clk_i);
    ppu_hi_i = 3'd4; cpu_addr_i = 16'h7EF2; cpu_data_i = 8'h55; cpu_rw_i = 1'b0; m2_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #1 chk(chr_bank_o == 8'h81, "R9 before m2 fall", chr_bank_o, 8'h81);
    @(negedge clk_i); m2_i = 1'b0;
    @(negedge clk_i); cpu_rw_i = 1'b1;
    #1 chk(chr_bank_o == 8'h55, "R9 after m2 fall", chr_bank_o, 8'h55);

    // R10 R11 R12 RAM
    ram_read(16'h7F10, 1'b0, 8'h00, "R10 before key");
    cpu_cycle(16'h7EF9, 8'hA3, 1'b0);
    @(negedge clk_i);
    cpu_addr_i = 16'h7F10; cpu_data_i = 8'h5A; cpu_rw_i = 1'b0; m2_i = 1'b1;
    #1 chk(cpu_data_oe_o == 1'b0, "R12 no oe on write", cpu_data_oe_o, 0);
    @(negedge clk_i); @(negedge clk_i); m2_i = 1'b0;
    @(negedge clk_i); cpu_rw_i = 1'b1;
    ram_read(16'h7F10, 1'b1, 8'h5A, "R10 enabled read");
    ram_read(16'h7F90, 1'b1, 8'h5A, "R11 mirror read");
    cpu_cycle(16'h7FA0, 8'hC3, 1'b0);
    ram_read(16'h7F20, 1'b1, 8'hC3, "R11 mirror write");
    @(negedge clk_i);
    cpu_addr_i = 16'h7F10; cpu_rw_i = 1'b1; m2_i = 1'b0;
    #1 chk(cpu_data_oe_o == 1'b0, "R12 no oe m2 low", cpu_data_oe_o, 0);
    cpu_cycle(16'h7EF8, 8'hA2, 1'b0);
    ram_read(16'h7F10, 1'b0, 8'h00, "R10 wrong key");
    cpu_cycle(16'h7F10, 8'h11, 1'b0);
    cpu_cycle(16'h7EF8, 8'hA3, 1'b0);
    ram_read(16'h7F10, 1'b1, 8'h5A, "R10 dropped write");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule